// File: doc/BRIEF.md
# Command-Driven Successive-Approximation Conversion Controller

This block sits between a serial command port and an external comparator/DAC pair. Each accepted 4-bit command word does one of four things. It starts a 10-bit successive-approximation conversion on one of eight external channels. It starts a conversion on one of three built-in test levels. It changes the persistent conversion rate. Or it parks the block in a low-power state.

During a conversion the block drives a trial code to the external DAC. It reads back one comparator bit per step, resolves the code from the most significant bit down, and returns the result with a one-cycle strobe. An active-low end-of-conversion flag tracks the conversion. Test levels are resolved against a fixed internal level rather than the external comparator, so they always give known codes.

The serial port signals a new access with `access_start` and delivers a decoded command word with `cmd_valid`. The length of every bit step depends on the stored rate, which is counted in system clock cycles.

Top module: `sar_cmd_ctrl`

## Requirements
- R1: After synchronous reset, `eoc`=1, `chan_sel`=0, `test_src`=0, `result`=000h, `fast_rate`=0 (slow), `powered_down`=0 and `result_stale`=0.
- R2: A command 0h–7h accepted at a clock edge sets `chan_sel` to its low three bits, clears `test_src`, and takes `eoc` low after that edge.
- R3: The conversion starts with `trial_code`=200h. It resolves one bit per step from bit 9 down to bit 0. A trial bit is kept when `cmp_ge`=1, sampled one cycle after the trial code changes, and is cleared otherwise. The final result therefore equals the largest code not above the comparator's threshold.
- R4: `eoc` returns high exactly 10×STEP_FAST cycles (fast) or 10×STEP_SLOW cycles (slow) after the accepting edge. `result_strobe` is a one-cycle pulse in the cycle `eoc` rises.
- R5: Command 9h sets `fast_rate`=1 and Ah sets it to 0. The setting persists. Neither command starts a conversion or changes `result`.
- R6: Commands Bh, Ch and Dh set `test_src`=1 with `test_sel` 0, 1 and 2 respectively. They produce results 200h, 000h and 3FFh whatever `cmp_ge` does.
- R7: Command 8h sets `powered_down`=1 without a conversion. While powered down every command is ignored. A pulse on `access_start` clears `powered_down`.
- R8: Entering or leaving the low-power state leaves `fast_rate` unchanged.
- R9: The first result completed after leaving the low-power state has `result_stale`=1. The following result has `result_stale`=0.
- R10: Reserved commands Eh and Fh start no conversion and change no output.
- R11: A command presented while `eoc`=0 is ignored: the channel, rate and result are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| access_start | input | 1 | Pulse: new serial access began (wakes from low power) |
| cmd_valid | input | 1 | Pulse: `cmd_code` holds a complete command word |
| cmd_code | input | 4 | Command word |
| cmp_ge | input | 1 | External comparator: input at or above trial level |
| chan_sel | output | 3 | Selected external channel |
| test_src | output | 1 | A built-in test level is selected |
| test_sel | output | 2 | Test level: 0 mid, 1 zero, 2 full |
| trial_code | output | 10 | Trial code for the external DAC |
| eoc | output | 1 | High when idle, low while converting |
| result | output | 10 | Last conversion result |
| result_strobe | output | 1 | One-cycle pulse when `result` is updated |
| result_stale | output | 1 | Current result is the first one after wake-up |
| fast_rate | output | 1 | Stored rate: 1 fast, 0 slow |
| powered_down | output | 1 | Low-power state active |

## Verification
The bench counts cycles from the accepting edge to `eoc` rising under both rates. A timer that shared one step length, or that sampled the comparator on the wrong edge, would show a wrong count or a result off by one code. Inputs of 000h, 3FFh and 200h/1FFh exercise the keep-on-equal rule, where a strict comparison would lose the LSB. Test commands are run with the external comparator forced to a wrong answer, so a design that did not substitute the internal level would return garbage. The bench also sends commands while converting and while powered down, sends reserved codes and cycles power-down. A design that leaked any of these would change the channel, the rate or the result, or would miss the stale flag.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

    localparam int RES_W = 10;

    typedef enum logic [1:0] {
        LVL_MID  = 2'd0,
        LVL_ZERO = 2'd1,
        LVL_FULL = 2'd2
    } test_lvl_e;

    typedef enum logic [2:0] {
        OP_CHAN,
        OP_PDN,
        OP_FAST,
        OP_SLOW,
        OP_TEST,
        OP_NONE
    } op_e;

    typedef struct packed {
        op_e       op;
        logic [2:0] chan;
        test_lvl_e lvl;
    } cmd_s;

    function automatic cmd_s decode_cmd(input logic [3:0] c);
        cmd_s d;
        d.op   = OP_NONE;
        d.chan = c[2:0];
        d.lvl  = LVL_MID;
        if (!c[3]) begin
            d.op = OP_CHAN;
        end else begin
            case (c[2:0])
                3'd0: d.op = OP_PDN;
                3'd1: d.op = OP_FAST;
                3'd2: d.op = OP_SLOW;
                3'd3: begin d.op = OP_TEST; d.lvl = LVL_MID;  end
                3'd4: begin d.op = OP_TEST; d.lvl = LVL_ZERO; end
                3'd5: begin d.op = OP_TEST; d.lvl = LVL_FULL; end
                default: d.op = OP_NONE;
            endcase
        end
        return d;
    endfunction

    function automatic logic [RES_W-1:0] level_code(input test_lvl_e l);
        case (l)
            LVL_MID:  return RES_W'(1) << (RES_W - 1);
            LVL_FULL: return {RES_W{1'b1}};
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/sarc_step_timer.sv
module sarc_step_timer #(
    parameter int STEP_FAST = 4,
    parameter int STEP_SLOW = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    output logic sample,
    output logic step_end
);
    localparam int MAXS = (STEP_SLOW > STEP_FAST) ? STEP_SLOW : STEP_FAST;
    localparam int CW   = $clog2(MAXS + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = fast ? CW'(STEP_FAST - 1) : CW'(STEP_SLOW - 1);

    always_ff @(posedge clk) begin
        if (rst || !run)      cnt <= '0;
        else if (cnt == last) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign sample   = run && (cnt == '0);
    assign step_end = run && (cnt == last);
endmodule

// File: rtl/sarc_sar_core.sv
module sarc_sar_core #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         sample,
    input  logic         step_end,
    input  logic         ge,
    output logic [W-1:0] trial,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] code
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    logic [IW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            trial <= '0;
            idx   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
            code  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                trial <= W'(1) << (W - 1);
                idx   <= IW'(W - 1);
                busy  <= 1'b1;
            end else if (busy) begin
                if (sample && !ge) trial[idx] <= 1'b0;
                if (step_end) begin
                    if (idx == '0) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        code <= trial;
                    end else begin
                        trial[idx - 1'b1] <= 1'b1;
                        idx <= idx - 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sar_cmd_ctrl.sv
module sar_cmd_ctrl #(
    parameter int STEP_FAST = 4,
    parameter int STEP_SLOW = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      access_start,
    input  logic                      cmd_valid,
    input  logic [3:0]                cmd_code,
    input  logic                      cmp_ge,
    output logic [2:0]                chan_sel,
    output logic                      test_src,
    output logic [1:0]                test_sel,
    output logic [sarc_pkg::RES_W-1:0] trial_code,
    output logic                      eoc,
    output logic [sarc_pkg::RES_W-1:0] result,
    output logic                      result_strobe,
    output logic                      result_stale,
    output logic                      fast_rate,
    output logic                      powered_down
);
    import sarc_pkg::*;

    initial begin
        if (STEP_FAST < 2 || STEP_SLOW < 2)
            $error("step lengths must be at least two cycles");
    end

    cmd_s       dcmd;
    logic       busy, accept, start, sample, step_end, ge_mux, done;
    test_lvl_e  lvl_q;
    logic       wake_q;

    assign dcmd   = decode_cmd(cmd_code);
    assign accept = cmd_valid && !busy && !powered_down;
    assign start  = accept && (dcmd.op == OP_CHAN || dcmd.op == OP_TEST);

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_sel     <= '0;
            test_src     <= 1'b0;
            lvl_q        <= LVL_MID;
            fast_rate    <= 1'b0;
            powered_down <= 1'b0;
            wake_q       <= 1'b0;
            result_stale <= 1'b0;
        end else begin
            if (accept) begin
                case (dcmd.op)
                    OP_CHAN: begin chan_sel <= dcmd.chan; test_src <= 1'b0; end
                    OP_TEST: begin test_src <= 1'b1; lvl_q <= dcmd.lvl; end
                    OP_FAST: fast_rate <= 1'b1;
                    OP_SLOW: fast_rate <= 1'b0;
                    OP_PDN:  powered_down <= 1'b1;
                    default: ;
                endcase
            end
            if (done) begin
                result_stale <= wake_q;
                wake_q       <= 1'b0;
            end
            if (access_start && powered_down) begin
                powered_down <= 1'b0;
                wake_q       <= 1'b1;
            end
        end
    end

    // test levels resolve against a fixed internal threshold
    assign ge_mux = test_src ? (level_code(lvl_q) >= trial_code) : cmp_ge;

    sarc_step_timer #(.STEP_FAST(STEP_FAST), .STEP_SLOW(STEP_SLOW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .fast     (fast_rate),
        .sample   (sample),
        .step_end (step_end)
    );

    sarc_sar_core #(.W(RES_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .sample   (sample),
        .step_end (step_end),
        .ge       (ge_mux),
        .trial    (trial_code),
        .busy     (busy),
        .done     (done),
        .code     (result)
    );

    assign eoc           = !busy;
    assign result_strobe = done;
    assign test_sel      = lvl_q;
endmodule

// File: rtl/sarc_checker.sv
module sarc_checker (
    input logic       clk,
    input logic       rst,
    input logic       access_start,
    input logic       cmd_valid,
    input logic [2:0] chan_sel,
    input logic       test_src,
    input logic [1:0] test_sel,
    input logic [9:0] trial_code,
    input logic       eoc,
    input logic [9:0] result,
    input logic       result_strobe,
    input logic       fast_rate,
    input logic       powered_down
);
    // R2
    a_r2_start_needs_cmd: assert property (@(posedge clk) disable iff (rst)
        $fell(eoc) |-> $past(cmd_valid));
    // R3
    a_r3_first_trial: assert property (@(posedge clk) disable iff (rst)
        $fell(eoc) |-> trial_code == 10'h200);
    // R4
    a_r4_strobe_with_eoc: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc) |-> result_strobe);
    a_r4_result_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> result_strobe || $stable(result));
    // R5
    a_r5_rate_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(fast_rate));
    // R6
    a_r6_mid_level: assert property (@(posedge clk) disable iff (rst)
        result_strobe && test_src && test_sel == 2'd0 |-> result == 10'h200);
    a_r6_full_level: assert property (@(posedge clk) disable iff (rst)
        result_strobe && test_src && test_sel == 2'd2 |-> result == 10'h3FF);
    // R7
    a_r7_pd_hold: assert property (@(posedge clk) disable iff (rst)
        powered_down && !access_start |=> powered_down);
    // R8
    a_r8_pd_keeps_rate: assert property (@(posedge clk) disable iff (rst)
        $changed(powered_down) |-> $stable(fast_rate));
    // R11
    a_r11_busy_chan: assert property (@(posedge clk) disable iff (rst)
        !eoc |=> $stable(chan_sel) && $stable(fast_rate));
endmodule

bind sar_cmd_ctrl sarc_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .access_start  (access_start),
    .cmd_valid     (cmd_valid),
    .chan_sel      (chan_sel),
    .test_src      (test_src),
    .test_sel      (test_sel),
    .trial_code    (trial_code),
    .eoc           (eoc),
    .result        (result),
    .result_strobe (result_strobe),
    .fast_rate     (fast_rate),
    .powered_down  (powered_down)
);

// File: tb/tb_sar_cmd_ctrl.sv
module tb_sar_cmd_ctrl;
    localparam int SF = 4;
    localparam int SS = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic access_start = 1'b0;
    logic cmd_valid = 1'b0;
    logic [3:0] cmd_code = 4'h0;
    logic cmp_ge;
    logic [2:0] chan_sel;
    logic test_src;
    logic [1:0] test_sel;
    logic [9:0] trial_code, result;
    logic eoc, result_strobe, result_stale, fast_rate, powered_down;

    logic [9:0] ain [8];
    logic force_cmp = 1'b0;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    assign cmp_ge = force_cmp ? 1'b1 : (ain[chan_sel] >= trial_code);

    sar_cmd_ctrl #(.STEP_FAST(SF), .STEP_SLOW(SS)) dut (
        .clk(clk), .rst(rst), .access_start(access_start), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmp_ge(cmp_ge), .chan_sel(chan_sel), .test_src(test_src),
        .test_sel(test_sel), .trial_code(trial_code), .eoc(eoc), .result(result),
        .result_strobe(result_strobe), .result_stale(result_stale),
        .fast_rate(fast_rate), .powered_down(powered_down)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // issue a command; returns just after the accepting edge (at negedge)
    task automatic send(input logic [3:0] c);
        @(negedge clk);
        cmd_code  = c;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wake();
        @(negedge clk);
        access_start = 1'b1;
        @(negedge clk);
        access_start = 1'b0;
    endtask

    // wait for eoc high; n = edges since accepting edge
    task automatic wait_done(output int n, output logic strobe);
        n = 0;
        strobe = 1'b0;
        while (n < 2000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (eoc) begin strobe = result_strobe; break; end
        end
    endtask

    task automatic t_reset();
        check(eoc == 1'b1, "R1 eoc", eoc, 1);
        check(chan_sel == 3'd0 && test_src == 1'b0, "R1 select", chan_sel, 0);
        check(result == 10'h0, "R1 result", result, 0);
        check(!fast_rate && !powered_down && !result_stale, "R1 flags",
              {fast_rate, powered_down, result_stale}, 0);
    endtask

    task automatic t_chan(input logic [2:0] ch, input logic [9:0] v, input int steps);
        int n;
        logic s;
        ain[ch] = v;
        send({1'b0, ch});
        check(eoc == 1'b0, "R2 eoc low", eoc, 0);
        check(chan_sel == ch && !test_src, "R2 chan_sel", chan_sel, ch);
        check(trial_code == 10'h200, "R3 first trial", trial_code, 10'h200);
        wait_done(n, s);
        check(n == 10 * steps, "R4 conversion length", n, 10 * steps);
        check(s == 1'b1, "R4 strobe", s, 1);
        check(result == v, "R3 result", result, v);
        @(negedge clk);
        check(result_strobe == 1'b0, "R4 strobe one cycle", result_strobe, 0);
    endtask

    task automatic t_rate();
        logic [9:0] r0;
        r0 = result;
        send(4'h9);
        check(fast_rate == 1'b1 && eoc, "R5 fast set", fast_rate, 1);
        repeat (5) @(negedge clk);
        check(result == r0 && eoc, "R5 no result", result, r0);
        t_chan(3'd2, 10'h155, SF);
        send(4'hA);
        check(fast_rate == 1'b0 && eoc, "R5 slow set", fast_rate, 0);
        t_chan(3'd6, 10'h2AA, SS);
    endtask

    task automatic t_test(input logic [3:0] c, input logic [1:0] sel, input logic [9:0] exp);
        int n;
        logic s;
        force_cmp = 1'b1;
        send(c);
        check(test_src && test_sel == sel, "R6 test select", test_sel, sel);
        wait_done(n, s);
        check(result == exp, "R6 test result", result, exp);
        force_cmp = 1'b0;
    endtask

    task automatic t_reserved(input logic [3:0] c);
        logic [9:0] r0;
        logic [2:0] ch0;
        r0 = result;
        ch0 = chan_sel;
        send(c);
        repeat (3) @(negedge clk);
        check(eoc && result == r0 && chan_sel == ch0 && !powered_down,
              "R10 reserved no effect", result, r0);
    endtask

    task automatic t_busy();
        logic [9:0] r0;
        int n;
        logic s;
        ain[1] = 10'h0F0;
        send(4'h1);
        send(4'h9);
        send(4'h5);
        check(fast_rate == 1'b0, "R11 rate ignored", fast_rate, 0);
        check(chan_sel == 3'd1, "R11 chan ignored", chan_sel, 1);
        wait_done(n, s);
        check(result == 10'h0F0, "R11 result intact", result, 10'h0F0);
        r0 = result;
        repeat (3) @(negedge clk);
        check(eoc && result == r0, "R11 no queued start", eoc, 1);
    endtask

    task automatic t_power();
        send(4'h9);
        send(4'h8);
        check(powered_down && eoc, "R7 power down", powered_down, 1);
        check(fast_rate == 1'b1, "R8 rate kept on entry", fast_rate, 1);
        send(4'h3);
        check(eoc && powered_down && chan_sel != 3'd3, "R7 commands ignored", chan_sel, 0);
        send(4'hA);
        check(fast_rate == 1'b1, "R7 rate cmd ignored", fast_rate, 1);
        wake();
        check(!powered_down, "R7 wake", powered_down, 0);
        check(fast_rate == 1'b1, "R8 rate kept on exit", fast_rate, 1);
        t_chan(3'd4, 10'h123, SF);
        check(result_stale == 1'b1, "R9 first after wake stale", result_stale, 1);
        t_chan(3'd5, 10'h321, SF);
        check(result_stale == 1'b0, "R9 second fresh", result_stale, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) ain[i] = 10'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_chan(3'd0, 10'h000, SS);
        t_chan(3'd7, 10'h3FF, SS);
        t_chan(3'd3, 10'h200, SS);
        t_chan(3'd1, 10'h1FF, SS);
        t_rate();
        t_test(4'hB, 2'd0, 10'h200);
        t_test(4'hC, 2'd1, 10'h000);
        t_test(4'hD, 2'd2, 10'h3FF);
        t_chan(3'd0, 10'h0AB, SS);
        check(!test_src, "R2 leaves test", test_src, 0);
        t_reserved(4'hE);
        t_reserved(4'hF);
        t_busy();
        t_power();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule